// File: doc/BRIEF.md
# Predicated last-active-element extractor

This datapath block takes a vector operand, a predicate holding one bit per byte of that vector, and a scalar accumulator. The vector is viewed as a row of equal-width elements whose width follows a 2-bit size code. The block finds the highest-numbered element whose governing predicate bit is set and writes that element, zero-extended to 64 bits, as the new scalar value. When no element is governed active, the new scalar is the accumulator's own low element-width bits, zero-extended, so the operation is destructive on the accumulator.

A mode input picks either the highest active element itself or the element just above it. In the second mode the chosen index wraps to element 0 when the highest active element is the top one. The search is a combinational priority scan done in the start cycle; the result and a valid strobe are registered on the following clock edge. Instruction decode, the register files and any enable or trap checks sit outside this block.

Top module: `lastx_extract`

## Requirements
- R1: The size code sets the element width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. The vector of VLEN bits (a multiple of 64, default 256) holds VLEN divided by that width elements, element k occupying vector bits starting at k times the width.
- R2: Element k is active exactly when predicate bit k times (width/8) is 1, the bit for its lowest-addressed byte. Every other predicate bit has no effect on the result.
- R3: With mode_after low and at least one active element, the result is the element at the index of the highest active element.
- R4: With mode_after high and at least one active element, the result is the element at one above the highest active index.
- R5: With mode_after high, when the highest active element is the top element of the vector, the result is element 0.
- R6: With no active element, in either mode, the result is the low element-width bits of scalar_in, zero-extended.
- R7: Every result bit at or above the element width is 0.
- R8: valid is high in exactly the cycle after a cycle with start high, and result updates only then; inputs are sampled in the start cycle only and result holds its value until the next start.
- R9: After a synchronous active-low reset, valid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sample the operands and compute this cycle |
| mode_after | input | 1 | 0: take the highest active element; 1: take the element after it |
| size | input | 2 | Element size code (00 byte, 01 half, 10 word, 11 double) |
| vec | input | VLEN | Vector operand |
| pred | input | VLEN/8 | Byte-granular governing predicate |
| scalar_in | input | 64 | Current accumulator value |
| valid | output | 1 | Result strobe, one cycle after start |
| result | output | 64 | New accumulator value, zero-extended |

## Verification
Each result is due at the first rising edge after the cycle in which start is high, so the bench drives on falling edges and its monitor compares on the next falling edge whenever valid is seen, popping the expected value that the driver queued in the start cycle. A valid with nothing queued, or a queue left non-empty after the drain, counts as a mismatch. The hold check changes every operand with start low and looks at result and valid three falling edges later, after two rising edges have passed without a start.

// File: rtl/lastx_pkg.sv
// Package: shared constants and helpers for the last-active-element extractor.
// Assumes the size code is a 2-bit field where element width = 8 << code.
package lastx_pkg;

    localparam int SCALAR_W = 64;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'b00,
        ESZ_HALF = 2'b01,
        ESZ_WORD = 2'b10,
        ESZ_DBL  = 2'b11
    } esz_code_t;

    // Element width in bits for a size code.
    function automatic int elem_bits(input logic [1:0] code);
        return 8 << code;
    endfunction

endpackage

// File: rtl/lastx_lane_scan.sv
// Module: lastx_lane_scan
// Finds the highest active element of the vector for each element size in
// parallel, selects the one matching the size code, and turns it into the
// element index to extract (optionally the next one, wrapping to 0).
// Assumes VLEN is a multiple of 64, so every size has a whole number of lanes.
module lastx_lane_scan
    import lastx_pkg::*;
#(
    parameter  int VLEN   = 256,
    localparam int PRED_W = VLEN / 8,
    localparam int IDX_W  = $clog2(PRED_W)
) (
    input  logic [PRED_W-1:0] pred,
    input  logic [1:0]        size,
    input  logic              mode_after,
    output logic              any_active,
    output logic [IDX_W-1:0]  raw_idx,
    output logic [IDX_W-1:0]  sel_idx
);

    logic [3:0]       hit_s;
    logic [IDX_W-1:0] top_s [4];

    // One priority scanner per element size.
    for (genvar s = 0; s < 4; s++) begin : g_size
        localparam int EB    = 1 << s;
        localparam int LANES = PRED_W / EB;

        logic             hit;
        logic [IDX_W-1:0] top;

        // Scan lanes from the top down; the first lane with its low byte set wins.
        always_comb begin
            hit = 1'b0;
            top = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
                if (!hit && pred[i*EB]) begin
                    hit = 1'b1;
                    top = IDX_W'(i);
                end
            end
        end

        assign hit_s[s] = hit;
        assign top_s[s] = top;
    end

    // Lane count for a size code, one bit wider than the index.
    function automatic logic [IDX_W:0] lane_count(input logic [1:0] code);
        return (IDX_W+1)'(PRED_W >> code);
    endfunction

    // Pick the scanner result that matches the requested element size.
    always_comb begin
        any_active = hit_s[size];
        raw_idx    = top_s[size];
    end

    logic [IDX_W:0] next_idx;

    // Form the extraction index: the hit itself, or the lane after it with wrap.
    always_comb begin
        next_idx = {1'b0, raw_idx} + 1'b1;
        if (!any_active) begin
            sel_idx = '0;
        end else if (!mode_after) begin
            sel_idx = raw_idx;
        end else if (next_idx == lane_count(size)) begin
            sel_idx = '0;
        end else begin
            sel_idx = next_idx[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/lastx_elem_pick.sv
// Module: lastx_elem_pick
// Extracts one element of the vector at a given index for each element size,
// zero-extends it to the scalar width, and substitutes the zero-extended low
// bits of the incoming scalar when no lane is active.
// Assumes idx is below the lane count of the selected size.
module lastx_elem_pick
    import lastx_pkg::*;
#(
    parameter  int VLEN   = 256,
    localparam int PRED_W = VLEN / 8,
    localparam int IDX_W  = $clog2(PRED_W)
) (
    input  logic [VLEN-1:0]     vec,
    input  logic [1:0]          size,
    input  logic [IDX_W-1:0]    idx,
    input  logic                any_active,
    input  logic [SCALAR_W-1:0] scalar_in,
    output logic [SCALAR_W-1:0] pick_out
);

    logic [SCALAR_W-1:0] elem_s [4];
    logic [SCALAR_W-1:0] keep_s [4];

    // One extractor per element size.
    for (genvar s = 0; s < 4; s++) begin : g_size
        localparam int ESZ = 8 << s;

        logic [VLEN-1:0] shifted;

        // Bring the addressed element down to bit 0.
        always_comb shifted = vec >> (int'(idx) * ESZ);

        // Zero-extend both the extracted element and the fallback value.
        always_comb begin
            elem_s[s] = SCALAR_W'(shifted[ESZ-1:0]);
            keep_s[s] = SCALAR_W'(scalar_in[ESZ-1:0]);
        end
    end

    // Choose the element or the fallback for the requested size.
    always_comb begin
        pick_out = any_active ? elem_s[size] : keep_s[size];
    end

endmodule

// File: rtl/lastx_extract.sv
// Module: lastx_extract (top)
// Conditional last-active-element extraction into a 64-bit accumulator.
// Operands are sampled only in a cycle with start high; result and valid are
// registered on the following rising edge. Reset is synchronous, active low.
// Assumes VLEN is a multiple of 64.
module lastx_extract
    import lastx_pkg::*;
#(
    parameter  int VLEN   = 256,
    localparam int PRED_W = VLEN / 8,
    localparam int IDX_W  = $clog2(PRED_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode_after,
    input  logic [1:0]          size,
    input  logic [VLEN-1:0]     vec,
    input  logic [PRED_W-1:0]   pred,
    input  logic [SCALAR_W-1:0] scalar_in,
    output logic                valid,
    output logic [SCALAR_W-1:0] result
);

    logic                any_active;
    logic [IDX_W-1:0]    raw_idx;
    logic [IDX_W-1:0]    sel_idx;
    logic [SCALAR_W-1:0] pick_out;

    lastx_lane_scan #(.VLEN(VLEN)) u_scan (
        .pred       (pred),
        .size       (size),
        .mode_after (mode_after),
        .any_active (any_active),
        .raw_idx    (raw_idx),
        .sel_idx    (sel_idx)
    );

    lastx_elem_pick #(.VLEN(VLEN)) u_pick (
        .vec        (vec),
        .size       (size),
        .idx        (sel_idx),
        .any_active (any_active),
        .scalar_in  (scalar_in),
        .pick_out   (pick_out)
    );

    // Register the strobe and capture the new accumulator value on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            result <= '0;
        end else begin
            valid <= start;
            if (start) begin
                result <= pick_out;
            end
        end
    end

    // R8: a start is always answered by valid on the next cycle.
    p_valid_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    // R8: valid never appears without a start in the cycle before.
    p_valid_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(start));

    // R8: without start the accumulator output holds.
    p_hold_without_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    // R3: the lane the scanner reports has its lowest-byte predicate bit set.
    p_hit_lane_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && any_active) |-> pred[int'(raw_idx) << size]);

    // R5: the extraction index never runs past the lane count.
    p_index_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (int'(sel_idx) < (PRED_W >> size)));

endmodule

// File: tb/lastx_extract_test.sv
// Scoreboard bench: a driver task queues expected results, a monitor compares.
module lastx_extract_test;

    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            mode_after = 1'b0;
    logic [1:0]      size = 2'b00;
    logic [VLEN-1:0] vec = '0;
    logic [PW-1:0]   pred = '0;
    logic [63:0]     scalar_in = '0;
    logic            valid;
    logic [63:0]     result;

    int       compared = 0;
    int       mismatched = 0;
    bit       done = 1'b0;
    sb_item_t sbq[$];

    always #5 clk = ~clk;

    lastx_extract #(.VLEN(VLEN)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_after (mode_after),
        .size       (size),
        .vec        (vec),
        .pred       (pred),
        .scalar_in  (scalar_in),
        .valid      (valid),
        .result     (result)
    );

    // Behavioural model written from the requirements.
    function automatic logic [63:0] model(input logic [1:0] sz, input logic aft,
                                          input logic [VLEN-1:0] v, input logic [PW-1:0] p,
                                          input logic [63:0] s);
        int          esz  = 8 << sz;
        int          n    = VLEN / esz;
        int          last = -1;
        logic [63:0] mask = (esz == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << esz) - 64'd1);
        for (int i = 0; i < n; i++) begin
            if (p[i*(esz/8)]) last = i;
        end
        if (last < 0) return s & mask;
        if (aft) begin
            last = last + 1;
            if (last >= n) last = 0;
        end
        return 64'(v >> (last * esz)) & mask;
    endfunction

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int w = 0; w < VLEN / 32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [63:0] rand64();
        return {$urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation on a falling edge and queue its expected result.
    task automatic issue(input logic [1:0] sz, input logic aft, input logic [VLEN-1:0] v,
                         input logic [PW-1:0] p, input logic [63:0] s, input string tag);
        sb_item_t it;
        @(negedge clk);
        start      = 1'b1;
        size       = sz;
        mode_after = aft;
        vec        = v;
        pred       = p;
        scalar_in  = s;
        it.exp     = model(sz, aft, v, p, s);
        it.tag     = tag;
        sbq.push_back(it);
    endtask

    // Monitor: every valid pops and compares one queued result.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R8 unexpected valid", result, 64'd0);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(result === it.exp, it.tag, result, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [VLEN-1:0] v;
        logic [PW-1:0]   p;
        logic [63:0]     s;
        logic [63:0]     held;

        // R9: reset state.
        repeat (3) @(negedge clk);
        check(valid === 1'b0, "R9 valid", {63'd0, valid}, 64'd0);
        check(result === 64'd0, "R9 result", result, 64'd0);
        rst_n = 1'b1;

        for (int sz = 0; sz < 4; sz++) begin
            for (int aft = 0; aft < 2; aft++) begin
                int eb = 1 << sz;
                int n  = PW / eb;
                v = rand_vec();
                s = rand64();
                // R6: no active lane.
                issue(2'(sz), aft[0], v, '0, s, "R6");
                // R7: fallback with an all-ones accumulator.
                issue(2'(sz), aft[0], v, '0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
                // Only lane 0 active.
                issue(2'(sz), aft[0], v, PW'(1), s, aft ? "R4" : "R3");
                // Only the top lane active; wraps in after mode.
                p = '0;
                p[(n-1)*eb] = 1'b1;
                issue(2'(sz), aft[0], v, p, s, aft ? "R5" : "R3");
                if (sz > 0) begin
                    // R2: only non-lowest byte bits set.
                    p = '1;
                    for (int k = 0; k < n; k++) p[k*eb] = 1'b0;
                    issue(2'(sz), aft[0], v, p, s, "R2");
                    // R2: lane 1 active under extra junk bits.
                    p[eb] = 1'b1;
                    issue(2'(sz), aft[0], v, p, s, "R2");
                end
                for (int r = 0; r < 3; r++) begin
                    p = PW'($urandom & $urandom & $urandom);
                    issue(2'(sz), aft[0], rand_vec(), p, rand64(), "R1/R7");
                end
            end
        end
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R8 drained", 64'(sbq.size()), 64'd0);

        // R8: operands ignored while start is low; result holds.
        v = rand_vec();
        issue(2'b10, 1'b0, v, PW'(16), 64'h1234, "R3");
        held = model(2'b10, 1'b0, v, PW'(16), 64'h1234);
        @(negedge clk);
        start     = 1'b0;
        vec       = ~v;
        pred      = '1;
        scalar_in = 64'hDEAD_BEEF_0BAD_F00D;
        size      = 2'b11;
        repeat (2) @(negedge clk);
        check(result === held, "R8 hold", result, held);
        check(valid === 1'b0, "R8 valid low", {63'd0, valid}, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule